// File: doc/BRIEF.md
# Asynchronous SRAM access sequencer

This block lets a clocked design read and write an external 128K x 8 asynchronous static RAM. The host offers one request at a time: a direction flag, a 17-bit byte address and, for stores, an 8-bit value. The block then plays out the memory's access phases on its pins and returns a one-cycle completion strobe. For loads, the fetched byte is returned with the strobe.

The memory has two selects of opposite sense. `mem_cs_n` must be low and `mem_cs` must be high for the memory to respond. Between accesses the block parks both selects in the deselected state, which puts the memory in standby with its outputs floating.

Each phase lasts a whole number of clock cycles. That number is the ceiling of the memory's minimum time divided by the clock period, and both are given in picoseconds as parameters. The data pins are split into an output value, a driver enable and an input value, so the pad ring builds the tristate.

When a store follows a load, the block inserts a deselected gap of N_TA cycles. This lets the memory's output drivers switch off before the block drives the bus.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, the block sets mem_cs_n=1, mem_cs=0, mem_we_n=1, mem_oe_n=1, mem_dq_oe=0, req_ready=1 and rsp_done=0.
- R2: req_ready is high only when the block is idle. A request is taken on a clock edge where req_valid and req_ready are both high. req_ready stays low from the cycle after that edge until the access completes.
- R3: A load keeps both selects active with mem_we_n=1 and mem_oe_n=0. It samples mem_dq_i at the end of its access phase, only after both the address-access time and the output-enable access time have elapsed. rsp_done and rsp_rdata appear in cycle 2+N_RD after the accepting edge, where N_RD = max(1, ceil(T_AA), ceil(T_OE), ceil(T_RC)-2).
- R4: A store drives mem_dq_o with mem_dq_oe=1 for the whole selected window. It pulls mem_we_n low for N_WP cycles, where N_WP = max(1, ceil(T_WP), ceil(T_AW)-1, ceil(T_DW)-1). When mem_we_n rises, the address has been stable for at least T_AW and the data for at least T_DW, so the memory stores the byte.
- R5: mem_addr changes only on the edge that accepts a request. It never changes while mem_we_n is low.
- R6: Each selected window (mem_cs_n low) lasts at least T_RC. A store's window is 1+N_WP+N_REC cycles, where N_REC = max(1, ceil(T_RC)-1-N_WP).
- R7: mem_dq_oe is never high while mem_oe_n is low. A store accepted after a load first spends N_TA = max(1, ceil(T_OHZ)) deselected cycles, so mem_dq_oe rises at least T_OHZ after mem_oe_n rose.
- R8: rsp_done is a single-cycle pulse, given once per accepted request. For a store it comes in cycle 2+N_WP+N_REC after acceptance, plus N_TA if the previous access was a load.
- R9: Whenever req_ready is high, the memory is deselected (mem_cs_n=1, mem_cs=0) and mem_dq_oe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Byte to store |
| rsp_done | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | 8 | Byte fetched by the last load |
| mem_addr | output | 17 | Memory address bus |
| mem_cs_n | output | 1 | Memory select, active low |
| mem_cs | output | 1 | Memory select, active high |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_dq_o | output | 8 | Data toward the memory |
| mem_dq_oe | output | 1 | Enable for the data drivers |
| mem_dq_i | input | 8 | Data from the memory |

## Verification
A wrong state or cycle count in the sequencer shows at the ports within one access. The completion strobe arrives on the wrong cycle. Or the memory model's clock-free time checks fire on the strobe or select edge where the window is too short.

A wrong phase decode has other symptoms. It shows as a bus fight, a write strobe without driven data, or an address moving under the strobe. Each of these is flagged in the cycle it happens.

Corrupted address or data capture shows one access later, as a byte read back that differs from the scoreboard.

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl #(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 8,
  parameter int CLK_PS   = 20000,
  parameter int T_AA_PS  = 10000,
  parameter int T_OE_PS  = 5000,
  parameter int T_WP_PS  = 7000,
  parameter int T_AW_PS  = 8000,
  parameter int T_DW_PS  = 5000,
  parameter int T_OHZ_PS = 3000,
  parameter int T_RC_PS  = 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_cs,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  function automatic int cyc(input int t_ps);
    return (t_ps + CLK_PS - 1) / CLK_PS;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int N_RD  = imax(imax(1, cyc(T_AA_PS)), imax(cyc(T_OE_PS), cyc(T_RC_PS) - 2));
  localparam int N_WP  = imax(imax(1, cyc(T_WP_PS)), imax(cyc(T_AW_PS) - 1, cyc(T_DW_PS) - 1));
  localparam int N_REC = imax(1, cyc(T_RC_PS) - 1 - N_WP);
  localparam int N_TA  = imax(1, cyc(T_OHZ_PS));
  localparam int N_MAX = imax(imax(N_RD, N_WP), imax(N_REC, N_TA));
  localparam int CNT_W = imax(1, $clog2(N_MAX + 1));

  typedef enum logic [2:0] {
    IDLE, READ_SETUP, READ_WAIT, READ_CAPTURE,
    TURNAROUND, WRITE_SETUP, WRITE_PULSE, WRITE_RECOVER
  } st_t;

  st_t              st, nxt;
  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic             last_rd;
  logic             accept;

  assign req_ready = (st == IDLE);
  assign accept    = req_ready && req_valid;

  function automatic logic [CNT_W-1:0] phase_len(input st_t s);
    case (s)
      READ_WAIT:     return CNT_W'(N_RD - 1);
      TURNAROUND:    return CNT_W'(N_TA - 1);
      WRITE_PULSE:   return CNT_W'(N_WP - 1);
      WRITE_RECOVER: return CNT_W'(N_REC - 1);
      default:       return '0;
    endcase
  endfunction

  always_comb begin
    nxt = st;
    case (st)
      IDLE:          if (req_valid) nxt = req_write ? (last_rd ? TURNAROUND : WRITE_SETUP) : READ_SETUP;
      READ_SETUP:    nxt = READ_WAIT;
      READ_WAIT:     if (cnt == '0) nxt = READ_CAPTURE;
      READ_CAPTURE:  nxt = IDLE;
      TURNAROUND:    if (cnt == '0) nxt = WRITE_SETUP;
      WRITE_SETUP:   nxt = WRITE_PULSE;
      WRITE_PULSE:   if (cnt == '0) nxt = WRITE_RECOVER;
      WRITE_RECOVER: if (cnt == '0) nxt = IDLE;
      default:       nxt = IDLE;
    endcase
    cnt_nxt = (nxt != st) ? phase_len(nxt) : cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= IDLE;
      cnt       <= '0;
      last_rd   <= 1'b0;
      mem_cs_n  <= 1'b1;
      mem_cs    <= 1'b0;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      mem_addr  <= '0;
      mem_dq_o  <= '0;
      rsp_rdata <= '0;
      rsp_done  <= 1'b0;
    end else begin
      st        <= nxt;
      cnt       <= cnt_nxt;
      mem_cs_n  <= (nxt == IDLE) || (nxt == TURNAROUND);
      mem_cs    <= (nxt != IDLE) && (nxt != TURNAROUND);
      mem_we_n  <= (nxt != WRITE_PULSE);
      mem_oe_n  <= !((nxt == READ_SETUP) || (nxt == READ_WAIT));
      mem_dq_oe <= (nxt == WRITE_SETUP) || (nxt == WRITE_PULSE) || (nxt == WRITE_RECOVER);
      rsp_done  <= (nxt == READ_CAPTURE) || (st == WRITE_RECOVER && nxt == IDLE);
      if (accept) begin
        mem_addr <= req_addr;
        mem_dq_o <= req_wdata;
        last_rd  <= !req_write;
      end
      if (st == READ_WAIT && nxt == READ_CAPTURE) rsp_rdata <= mem_dq_i;
    end
  end

endmodule

module sram_async_ctrl_chk #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_done,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs_n,
  input logic              mem_cs,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe
);

  p_idle_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs_n == !mem_cs);

  p_busy_no_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n |-> !req_ready);

  p_read_pins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && !mem_cs_n && mem_cs));

  p_write_pins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_dq_oe && !mem_cs_n && mem_cs));

  p_addr_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> $stable(mem_addr));

  p_no_fight_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  p_idle_standby_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && !mem_cs && !mem_dq_oe));

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_done(rsp_done),
  .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_cs(mem_cs),
  .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/test_sram_async_ctrl.sv
`timescale 1ns/1ps
module test_sram_async_ctrl;
  localparam int AW = 17, DW = 8;
  localparam int CLK_PS = 20000, TAA = 45000, TOE = 20000, TWP = 30000;
  localparam int TAW = 38000, TDW = 25000, TOHZ = 50000, TRC = 90000;
  // phase counts from the ceiling rules: N_RD=3, N_WP=2, N_REC=2, N_TA=3
  localparam int LAT_RD = 5, LAT_WR = 6, LAT_WR_TA = 9;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_done, mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [DW-1:0] rsp_rdata, mem_dq_o, mem_dq_i;
  logic [AW-1:0] mem_addr;

  always #10 clk = ~clk;

  sram_async_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_PS(CLK_PS), .T_AA_PS(TAA), .T_OE_PS(TOE),
    .T_WP_PS(TWP), .T_AW_PS(TAW), .T_DW_PS(TDW), .T_OHZ_PS(TOHZ), .T_RC_PS(TRC)) i_sram_async_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_cs(mem_cs), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i));

  int tests = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] init_val(input logic [AW-1:0] a);
    return a[7:0] ^ {1'b0, a[16:10]} ^ 8'h3C;
  endfunction

  // ---------------- memory model ----------------
  logic [DW-1:0] mstore [int];
  bit   mev = 1'b0;
  wire  msel = !mem_cs_n && mem_cs;
  wire  mdrv = msel && !mem_oe_n && mem_we_n;
  realtime t_addr = -1.0e6, t_oef = -1.0e6, t_oer = -1.0e6, t_wef = -1.0e6, t_dq = -1.0e6, t_sel = -1.0e6;
  bit we_armed = 1'b0, sel_armed = 1'b0;

  function automatic longint ps(input realtime t);
    return longint'(t * 1000.0);
  endfunction

  always @(mem_addr or mem_dq_o or mem_dq_oe or mem_cs_n or mem_cs or mem_oe_n or mem_we_n or mev) begin
    if (mdrv) mem_dq_i = mstore.exists(int'(mem_addr)) ? mstore[int'(mem_addr)] : init_val(mem_addr);
    else      mem_dq_i = mem_dq_oe ? mem_dq_o : 8'hFF;
  end

  always @(mem_addr) begin
    if (rst_n && msel && !mem_we_n) chk(1'b0, "R5 address moved during write strobe", 1, 0);
    t_addr = $realtime;
  end
  always @(mem_dq_o) t_dq = $realtime;
  always @(negedge mem_oe_n) t_oef = $realtime;
  always @(posedge mem_oe_n) t_oer = $realtime;
  always @(negedge mem_we_n) begin t_wef = $realtime; we_armed = 1'b1; end
  always @(negedge mem_cs_n) begin t_sel = $realtime; sel_armed = 1'b1; end

  always @(posedge mem_we_n) if (we_armed && msel) begin
    chk(ps($realtime - t_wef) >= TWP, "R4 write pulse width", ps($realtime - t_wef), TWP);
    chk(ps($realtime - t_addr) >= TAW, "R4 address to write end", ps($realtime - t_addr), TAW);
    chk(ps($realtime - t_dq) >= TDW, "R4 data to write end", ps($realtime - t_dq), TDW);
    chk(mem_dq_oe, "R4 data driven at write end", mem_dq_oe, 1);
    mstore[int'(mem_addr)] = mem_dq_o;
    mev = !mev;
  end

  always @(posedge mem_cs_n) if (sel_armed)
    chk(ps($realtime - t_sel) >= TRC, "R6 selected window", ps($realtime - t_sel), TRC);

  always @(posedge mem_dq_oe) if (rst_n)
    chk(ps($realtime - t_oer) >= TOHZ, "R7 output disable before drive", ps($realtime - t_oer), TOHZ);

  longint snap_aa = 0, snap_oe = 0;
  always @(posedge clk) begin
    snap_aa = ps($realtime - t_addr);
    snap_oe = ps($realtime - t_oef);
  end

  // ---------------- scoreboard ----------------
  typedef struct packed { logic rd; logic [DW-1:0] exp; } item_t;
  item_t sbq[$];
  logic [DW-1:0] shadow [int];
  bit prev_done = 1'b0;

  always @(negedge clk) begin
    if (rst_n && mdrv && mem_dq_oe) chk(1'b0, "R7 bus fight", 1, 0);
    if (rst_n && rsp_done) begin
      chk(!prev_done, "R8 done longer than one cycle", 2, 1);
      if (sbq.size() == 0) chk(1'b0, "R8 unexpected done", 1, 0);
      else begin
        item_t it;
        it = sbq.pop_front();
        if (it.rd) begin
          chk(rsp_rdata == it.exp, "R3 read data", rsp_rdata, it.exp);
          chk(snap_aa >= TAA, "R3 address access time", snap_aa, TAA);
          chk(snap_oe >= TOE, "R3 output enable access time", snap_oe, TOE);
        end
      end
    end
    prev_done = rst_n && rsp_done;
  end

  bit last_was_rd = 1'b0;

  task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    item_t it;
    int lat, exp_lat;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    it.rd = !wr;
    it.exp = shadow.exists(int'(a)) ? shadow[int'(a)] : init_val(a);
    if (wr) shadow[int'(a)] = d;
    sbq.push_back(it);
    exp_lat = wr ? (last_was_rd ? LAT_WR_TA : LAT_WR) : LAT_RD;
    last_was_rd = !wr;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_addr = ~a; req_wdata = ~d;
    lat = 1;
    chk(!req_ready, "R2 ready low after accept", req_ready, 0);
    while (!rsp_done && lat < 40) begin
      @(negedge clk);
      lat++;
      if (!rsp_done) chk(!req_ready, "R2 ready low while busy", req_ready, 0);
    end
    chk(lat == exp_lat, wr ? "R8 write done latency" : "R3 read done latency", lat, exp_lat);
    while (!req_ready) @(negedge clk);
    chk(mem_cs_n && !mem_cs && !mem_dq_oe, "R9 standby in idle", {mem_cs_n, mem_cs, mem_dq_oe}, 3'b100);
  endtask

  initial begin
    #(20 * 200000);
    chk(1'b0, "watchdog expired", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe, req_ready, rsp_done} == 7'b1011010,
        "R1 reset state", {mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe, req_ready, rsp_done}, 7'b1011010);
    rst_n = 1'b1;
    @(negedge clk);
    chk({mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe, req_ready, rsp_done} == 7'b1011010,
        "R1 idle after reset", {mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe, req_ready, rsp_done}, 7'b1011010);

    access(1'b1, 17'h00000, 8'hA5);   // R4 write after reset, no turnaround
    access(1'b1, 17'h1FFFF, 8'h5A);   // R4 back-to-back write, top address
    access(1'b0, 17'h00000, 8'h00);   // R3 read back
    access(1'b0, 17'h1FFFF, 8'h00);   // R3
    access(1'b0, 17'h0ABCD, 8'h00);   // R3 unwritten location
    access(1'b1, 17'h0ABCD, 8'h11);   // R7 write after read takes the turnaround
    access(1'b1, 17'h0ABCD, 8'h22);   // R4 overwrite
    access(1'b0, 17'h0ABCD, 8'h00);   // R3 newest value
    for (int i = 0; i < 24; i++) begin
      logic [AW-1:0] a;
      a = AW'((i * 5381 + 77) & 17'h1FFFF);
      access(i % 3 != 2, a, DW'(i * 37 + 1));
      access(1'b0, a, 8'h00);
    end
    access(1'b0, 17'h00000, 8'h00);   // R5 first location still intact
    repeat (4) @(negedge clk);
    chk(sbq.size() == 0, "R8 one done per request", sbq.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule